// File: doc/BRIEF.md
# Two-Axis Step Schedule Sequencer

This block plays out precomputed stepper motion for two motors. A command holds one direction bit for each motor and a fixed-length list of 32-bit timing words. The steps for both motors share that one list: the top bit of each word names the motor and the low 31 bits give the wait, in clock cycles, before that step. A word whose low 31 bits are all zero ends the list early.

Commands enter through a valid/ready push port and wait in a four-entry ring queue. The sequencer works on the command at the head of the queue. For each word it counts down the wait, drives the chosen motor's direction from the command, holds it for a set-up interval and then raises that motor's step output for a fixed number of cycles. It keeps a signed step position for each motor. When the list is used up, the command leaves the queue and the next one starts. When the queue is empty the block sits idle with both step outputs low.

Top module: `dual_step_sequencer`

## Requirements
- R1: The queue holds at most QUEUE_DEPTH (4) commands. cmd_ready_o is low while four commands are held. A push offered while cmd_ready_o is low is dropped, and its steps never appear.
- R2: Bit 31 of a word selects the motor (0 = motor 0, 1 = motor 1). Only that motor's step output pulses, and the two step outputs are never high together.
- R3: Bits 30:0 of a word are a wait in cycles. Within one command, the rising edges of two consecutive steps are exactly wait + DIR_SETUP + PULSE_W + 1 cycles apart, where wait is the later word's value.
- R4: A word with bits 30:0 equal to zero ends the command. No later word of that command produces a step.
- R5: A command whose N_ENTRIES words are all nonzero produces exactly N_ENTRIES steps and is then retired.
- R6: Before a step, dir_o of the selected motor takes cmd_dir_i[motor] of that command. It holds that value for at least DIR_SETUP (2) cycles before the rising edge of step and stays stable while step is high. The other motor's dir_o does not change.
- R7: Each step pulse stays high for exactly PULSE_W (100) cycles.
- R8: Each motor's signed position (pos_o[POS_W*m +: POS_W]) goes up by one on a step with direction 1 and down by one on a step with direction 0. It changes in the cycle the step output rises.
- R9: With the queue empty, both step outputs stay low and no output changes.
- R10: After reset, cmd_ready_o is high and step_o, dir_o and both positions are zero.
- R11: Commands run in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_ready_o | output | 1 | The queue can accept a command |
| cmd_dir_i | input | 2 | Direction for each motor (bit m = motor m) |
| cmd_delays_i | input | N_ENTRIES*32 | Timing words; word k is at bits [32k +: 32] |
| step_o | output | 2 | Step pulse for each motor |
| dir_o | output | 2 | Direction for each motor |
| pos_o | output | 2*POS_W | Signed position; motor m is at bits [POS_W*m +: POS_W] |

## Verification
The bench measures every step edge and compares spacing, pulse width, direction set-up and the motor's identity against values it computes from the words it sent. A terminator in mid-list followed by nonzero words catches a design that reads past the end-of-list marker, because extra steps and position changes would appear. A list of eight nonzero words catches an off-by-one at the list boundary, which would show up as a lost or repeated step. The bench fills the queue and then offers a fifth command that carries five steps. Overflow would show as those steps and a position shift, and a wrong ring pointer would reorder the four accepted commands' motors and directions.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int NUM_AXES = 2;
  localparam int WORD_W   = 32;
  localparam int DLY_W    = WORD_W - 1;

  typedef enum logic [1:0] {
    S_FETCH = 2'd0,
    S_WAIT  = 2'd1,
    S_SETUP = 2'd2,
    S_PULSE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dss_cmd_fifo.sv
module dss_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  output logic             push_ready_o,
  input  logic [WIDTH-1:0] push_data_i,
  output logic             head_valid_o,
  output logic [WIDTH-1:0] head_data_o,
  input  logic             pop_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign push_ready_o = (cnt_q != CNT_W'(DEPTH));
  assign head_valid_o = (cnt_q != '0);
  assign head_data_o  = mem_q[rd_q];
  assign do_push      = push_valid_i & push_ready_o;
  assign do_pop       = pop_i & head_valid_o;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_next(wr_q);
      if (do_pop)  rd_q <= ptr_next(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  p_full_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_ready_o && !pop_i) |=> !push_ready_o);

  p_pop_nonempty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o);
endmodule

// File: rtl/dss_sequencer.sv
module dss_sequencer
  import dss_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int PULSE_W   = 100,
  parameter int DIR_SETUP = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          head_valid_i,
  input  logic [NUM_AXES-1:0]           head_dir_i,
  input  logic [N_ENTRIES*WORD_W-1:0]   head_delays_i,
  output logic                          pop_o,
  output logic                          dir_we_o,
  output logic                          dir_val_o,
  output logic                          axis_o,
  output logic                          step_set_o,
  output logic                          step_clr_o
);
  localparam int IDX_W = $clog2(N_ENTRIES + 1);
  localparam int SEL_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [WORD_W-1:0] ent_arr [N_ENTRIES];
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign ent_arr[g] = head_delays_i[g*WORD_W +: WORD_W];
  end

  seq_state_e       state_q, state_d;
  logic [DLY_W-1:0] tmr_q, tmr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             axis_q, axis_d;
  logic [WORD_W-1:0] ent;
  logic             at_end, list_done, tmr_last;

  assign at_end    = (idx_q == IDX_W'(N_ENTRIES));
  assign ent       = at_end ? '0 : ent_arr[idx_q[SEL_W-1:0]];
  assign list_done = (ent[DLY_W-1:0] == '0);
  assign tmr_last  = (tmr_q == DLY_W'(1));
  assign axis_o    = axis_q;
  assign dir_val_o = head_dir_i[axis_q];

  always_comb begin
    state_d    = state_q;
    tmr_d      = tmr_q;
    idx_d      = idx_q;
    axis_d     = axis_q;
    pop_o      = 1'b0;
    dir_we_o   = 1'b0;
    step_set_o = 1'b0;
    step_clr_o = 1'b0;
    case (state_q)
      S_FETCH: begin
        if (head_valid_i) begin
          if (list_done) begin
            pop_o = 1'b1;
            idx_d = '0;
          end else begin
            state_d = S_WAIT;
            tmr_d   = ent[DLY_W-1:0];
            axis_d  = ent[WORD_W-1];
          end
        end
      end
      S_WAIT: begin
        if (tmr_last) begin
          dir_we_o = 1'b1;
          state_d  = S_SETUP;
          tmr_d    = DLY_W'(DIR_SETUP);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_SETUP: begin
        if (tmr_last) begin
          step_set_o = 1'b1;
          state_d    = S_PULSE;
          tmr_d      = DLY_W'(PULSE_W);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_PULSE: begin
        if (tmr_last) begin
          step_clr_o = 1'b1;
          state_d    = S_FETCH;
          idx_d      = idx_q + 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      default: state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      tmr_q   <= '0;
      idx_q   <= '0;
      axis_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      idx_q   <= idx_d;
      axis_q  <= axis_d;
    end
  end

  // list position never runs past the last word (R5)
  p_idx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(N_ENTRIES));

  p_head_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_FETCH) |-> head_valid_i);
endmodule

// File: rtl/dss_axis.sv
module dss_axis #(
  parameter int POS_W   = 16,
  parameter int PULSE_W = 100
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dir_we_i,
  input  logic                    dir_val_i,
  input  logic                    step_set_i,
  input  logic                    step_clr_i,
  output logic                    step_o,
  output logic                    dir_o,
  output logic signed [POS_W-1:0] pos_o
);
  logic                    step_q, dir_q;
  logic signed [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      dir_q  <= 1'b0;
      pos_q  <= '0;
    end else begin
      if (dir_we_i) dir_q <= dir_val_i;
      if (step_set_i) begin
        step_q <= 1'b1;
        pos_q  <= dir_q ? pos_q + 1'b1 : pos_q - 1'b1;
      end else if (step_clr_i) begin
        step_q <= 1'b0;
      end
    end
  end

  assign step_o = step_q;
  assign dir_o  = dir_q;
  assign pos_o  = pos_q;

  localparam int HW = $clog2(PULSE_W + 1) + 1;
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt_q <= '0;
    else if (step_q) hi_cnt_q <= hi_cnt_q + 1'b1;
    else             hi_cnt_q <= '0;
  end

  p_pulse_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(step_q) |-> hi_cnt_q == HW'(PULSE_W));

  p_dir_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_q) |-> (dir_q == $past(dir_q)) && (dir_q == $past(dir_q, 2)));

  p_dir_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |-> $stable(dir_q));

  p_pos_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(step_q) && dir_q) |-> pos_q == $past(pos_q) + 1'b1);

  p_pos_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(step_q) && !dir_q) |-> pos_q == $past(pos_q) - 1'b1);

  p_pos_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(step_q) |-> $stable(pos_q));
endmodule

// File: rtl/dual_step_sequencer.sv
module dual_step_sequencer
  import dss_pkg::*;
#(
  parameter int N_ENTRIES   = 8,
  parameter int QUEUE_DEPTH = 4,
  parameter int PULSE_W     = 100,
  parameter int DIR_SETUP   = 2,
  parameter int POS_W       = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  output logic                          cmd_ready_o,
  input  logic [NUM_AXES-1:0]           cmd_dir_i,
  input  logic [N_ENTRIES*WORD_W-1:0]   cmd_delays_i,
  output logic [NUM_AXES-1:0]           step_o,
  output logic [NUM_AXES-1:0]           dir_o,
  output logic [NUM_AXES*POS_W-1:0]     pos_o
);
  localparam int LIST_W = N_ENTRIES * WORD_W;
  localparam int CMD_W  = NUM_AXES + LIST_W;

  logic             q_valid, q_pop;
  logic [CMD_W-1:0] q_head;
  logic             dir_we, dir_val, seq_axis, step_set, step_clr;

  dss_cmd_fifo #(.DEPTH(QUEUE_DEPTH), .WIDTH(CMD_W)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_valid_i (cmd_valid_i),
    .push_ready_o (cmd_ready_o),
    .push_data_i  ({cmd_dir_i, cmd_delays_i}),
    .head_valid_o (q_valid),
    .head_data_o  (q_head),
    .pop_i        (q_pop)
  );

  dss_sequencer #(.N_ENTRIES(N_ENTRIES), .PULSE_W(PULSE_W), .DIR_SETUP(DIR_SETUP)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .head_valid_i  (q_valid),
    .head_dir_i    (q_head[CMD_W-1 -: NUM_AXES]),
    .head_delays_i (q_head[LIST_W-1:0]),
    .pop_o         (q_pop),
    .dir_we_o      (dir_we),
    .dir_val_o     (dir_val),
    .axis_o        (seq_axis),
    .step_set_o    (step_set),
    .step_clr_o    (step_clr)
  );

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    logic sel;
    assign sel = (seq_axis == 1'(g));
    dss_axis #(.POS_W(POS_W), .PULSE_W(PULSE_W)) u_axis (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dir_we_i   (dir_we & sel),
      .dir_val_i  (dir_val),
      .step_set_i (step_set & sel),
      .step_clr_i (step_clr & sel),
      .step_o     (step_o[g]),
      .dir_o      (dir_o[g]),
      .pos_o      (pos_o[g*POS_W +: POS_W])
    );
  end

  p_one_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_o));

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_valid |-> step_o == '0);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_valid && !$past(q_valid)) |-> ($stable(dir_o) && $stable(pos_o)));

  p_retire_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop |-> step_o == '0);
endmodule

// File: tb/dual_step_sequencer_tb.sv
module dual_step_sequencer_tb;
  localparam int N    = 8;
  localparam int PW   = 100;
  localparam int DS   = 2;
  localparam int PSW  = 16;
  localparam int EMAX = 256;

  logic           clk, rst_n;
  logic           cmd_valid, cmd_ready;
  logic [1:0]     cmd_dir;
  logic [N*32-1:0] cmd_delays;
  logic [1:0]     step, dir;
  logic [2*PSW-1:0] pos;

  dual_step_sequencer #(.N_ENTRIES(N), .QUEUE_DEPTH(4), .PULSE_W(PW),
                        .DIR_SETUP(DS), .POS_W(PSW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_dir_i(cmd_dir), .cmd_delays_i(cmd_delays), .step_o(step), .dir_o(dir),
    .pos_o(pos));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_fail = 0;
  int exp_pos [2];

  // step monitor, sampled at the falling edge
  int   ev_n = 0;
  int   ev_axis [EMAX];
  int   ev_cyc  [EMAX];
  int   ev_w    [EMAX];
  logic ev_dir  [EMAX];
  logic ev_dok  [EMAX];
  int   last_ev [2];
  logic [1:0] prev_step = '0, d1 = '0, d2 = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int a = 0; a < 2; a++) begin
        if (step[a] && !prev_step[a] && ev_n < EMAX) begin
          ev_axis[ev_n] = a;
          ev_cyc[ev_n]  = cyc;
          ev_w[ev_n]    = -1;
          ev_dir[ev_n]  = dir[a];
          ev_dok[ev_n]  = (dir[a] == d1[a]) && (dir[a] == d2[a]);
          last_ev[a]    = ev_n;
          ev_n++;
        end
        if (!step[a] && prev_step[a]) ev_w[last_ev[a]] = cyc - ev_cyc[last_ev[a]];
      end
      prev_step = step;
      d2 = d1;
      d1 = dir;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input int axis, input int d);
    return {axis[0], 31'(d)};
  endfunction

  function automatic int count_steps(input logic [31:0] e [N]);
    for (int k = 0; k < N; k++) if (e[k][30:0] == 0) return k;
    return N;
  endfunction

  function automatic int pos_of(input int a);
    logic signed [PSW-1:0] v;
    v = pos[a*PSW +: PSW];
    return int'(v);
  endfunction

  task automatic push_cmd(input logic [1:0] d, input logic [31:0] e [N]);
    int t;
    t = 0;
    @(negedge clk);
    while (!cmd_ready && t < 5000) begin @(negedge clk); t++; end
    cmd_dir   = d;
    for (int k = 0; k < N; k++) cmd_delays[k*32 +: 32] = e[k];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_events(input int target);
    int t;
    t = 0;
    while (ev_n < target && t < 20000) begin @(negedge clk); t++; end
    repeat (PW + 8) @(negedge clk);
  endtask

  // compare one command's steps starting at event index first
  task automatic verify_cmd(input string req, input int first, input logic [1:0] d,
                            input logic [31:0] e [N]);
    int n, a, i;
    n = count_steps(e);
    for (int k = 0; k < n; k++) begin
      i = first + k;
      a = int'(e[k][31]);
      chk("R2", $sformatf("%s motor of step %0d", req, k), ev_axis[i], a);
      chk("R6", $sformatf("%s dir at step %0d", req, k), ev_dir[i], d[a]);
      chk("R6", $sformatf("%s dir setup at step %0d", req, k), ev_dok[i], 1);
      chk("R7", $sformatf("%s width of step %0d", req, k), ev_w[i], PW);
      if (k > 0)
        chk("R3", $sformatf("%s spacing before step %0d", req, k),
            ev_cyc[i] - ev_cyc[i-1], int'(e[k][30:0]) + DS + PW + 1);
      exp_pos[a] += d[a] ? 1 : -1;
    end
  endtask

  task automatic check_pos(input string req);
    chk(req, "motor 0 position", pos_of(0), exp_pos[0]);
    chk(req, "motor 1 position", pos_of(1), exp_pos[1]);
  endtask

  task automatic t_reset();
    chk("R10", "ready after reset", cmd_ready, 1);
    chk("R10", "step after reset", step, 0);
    chk("R10", "dir after reset", dir, 0);
    check_pos("R10");
  endtask

  task automatic t_single_axis();
    logic [31:0] e [N];
    int base;
    e = '{mk(0,5), mk(0,5), mk(0,9), 0, 0, 0, 0, 0};
    base = ev_n;
    push_cmd(2'b01, e);
    wait_events(base + 3);
    chk("R3", "single axis step count", ev_n - base, 3);
    verify_cmd("R3", base, 2'b01, e);
    check_pos("R8");
  endtask

  task automatic t_interleave();
    logic [31:0] e [N];
    int base;
    e = '{mk(0,3), mk(1,7), mk(1,2), mk(0,10), mk(1,1), 0, 0, 0};
    base = ev_n;
    push_cmd(2'b01, e);
    wait_events(base + 5);
    chk("R2", "interleaved step count", ev_n - base, 5);
    verify_cmd("R2", base, 2'b01, e);
    chk("R6", "motor 1 dir after its down steps", dir[1], 0);
    chk("R6", "motor 0 dir after its up steps", dir[0], 1);
    check_pos("R8");
  endtask

  task automatic t_terminator();
    logic [31:0] e [N];
    int base;
    e = '{mk(1,4), mk(1,0), mk(1,9), mk(0,9), mk(0,3), 0, 0, 0};
    base = ev_n;
    push_cmd(2'b11, e);
    wait_events(base + 1);
    repeat (400) @(negedge clk);
    chk("R4", "steps after zero word", ev_n - base, 1);
    verify_cmd("R4", base, 2'b11, e);
    check_pos("R4");
    chk("R4", "motor 0 dir untouched", dir[0], 1);
  endtask

  task automatic t_full_list();
    logic [31:0] e [N];
    int base;
    for (int k = 0; k < N; k++) e[k] = mk(0, 1 + k);
    base = ev_n;
    push_cmd(2'b10, e);
    wait_events(base + N);
    repeat (200) @(negedge clk);
    chk("R5", "full list step count", ev_n - base, N);
    verify_cmd("R5", base, 2'b10, e);
    check_pos("R5");
    chk("R5", "queue free after full list", cmd_ready, 1);
  endtask

  task automatic t_queue_order();
    logic [31:0] ea [N], eb [N], ec [N], ed [N], ex [N];
    int base, snap;
    ea = '{mk(0,5), 0, 0, 0, 0, 0, 0, 0};
    eb = '{mk(1,6), 0, 0, 0, 0, 0, 0, 0};
    ec = '{mk(1,3), mk(1,4), 0, 0, 0, 0, 0, 0};
    ed = '{mk(0,8), 0, 0, 0, 0, 0, 0, 0};
    ex = '{mk(1,2), mk(1,2), mk(1,2), mk(1,2), mk(1,2), 0, 0, 0};
    base = ev_n;
    push_cmd(2'b01, ea);
    push_cmd(2'b10, eb);
    push_cmd(2'b00, ec);
    push_cmd(2'b10, ed);
    chk("R1", "ready with four queued", cmd_ready, 0);
    // offered while full: must be dropped
    cmd_dir   = 2'b11;
    for (int k = 0; k < N; k++) cmd_delays[k*32 +: 32] = ex[k];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_events(base + 5);
    repeat (1000) @(negedge clk);
    chk("R1", "steps from queued commands only", ev_n - base, 5);
    verify_cmd("R11", base,     2'b01, ea);
    verify_cmd("R11", base + 1, 2'b10, eb);
    verify_cmd("R11", base + 2, 2'b00, ec);
    verify_cmd("R11", base + 4, 2'b10, ed);
    check_pos("R1");
    // idle: nothing moves
    snap = ev_n;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (step != 0) begin
        chk("R9", "step while idle", step, 0);
        break;
      end
    end
    chk("R9", "no events while idle", ev_n - snap, 0);
    chk("R9", "step low while idle", step, 0);
    check_pos("R9");
    chk("R1", "ready after drain", cmd_ready, 1);
  endtask

  logic done = 1'b0;

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cmd_valid  = 1'b0;
    cmd_dir    = '0;
    cmd_delays = '0;
    exp_pos    = '{0, 0};
    last_ev    = '{0, 0};
    rst_n      = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_axis();
    t_interleave();
    t_terminator();
    t_full_list();
    t_queue_order();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule